// File: doc/BRIEF.md
# Integer Result Status Flag Generator

This block derives the fixed-point status flags that follow an integer arithmetic operation. It takes the operands, the finished 64-bit result and a handful of control bits. From these it computes five flags:

- unsigned carry at full width and at half width;
- signed overflow at full width and at half width;
- a sticky summary-overflow bit.

It also computes a four-bit condition field that classifies the signed result. The operand-forming and result logic sit upstream; this block only judges the result they produced.

All flags are held in registers. The registers load only on a cycle where `valid_i` is high. Each flag group has its own enable, so one operation can update carries and leave overflow and the condition field untouched. A two-bit mask lets an operation that already wrote a carry flag itself keep this block from overwriting it.

Top module: `int_flag_gen`

## Requirements
- R1: Reset (`rst_n` low) clears every output to 0. Outputs change only at a rising clock edge with `valid_i` high, and appear one cycle later.
- R2: With `inv_a_i` high the first operand is the bitwise complement of `opa_i`. With `imm_vld_i` high, `imm_i` replaces `opb_i` as the second operand, and a second operand then counts as present even if `has_b_i` is low.
- R3: When `carry_en_i` is high, `ca_o` becomes 1 exactly when some present operand is unsigned-greater than the 64-bit result. When `carry_en_i` is low, neither carry output changes.
- R4: When `add_op_i` is high, `ca32_o` becomes the XOR of bit 32 of the result, bit 32 of the first operand and bit 32 of the second operand. A missing second operand counts as 0.
- R5: When `add_op_i` is low, `ca32_o` becomes 1 exactly when the low 32 bits of some present operand are unsigned-greater than the low 32 bits of the result.
- R6: `carry_done_i[0]` high keeps `ca_o` unchanged, and `carry_done_i[1]` high keeps `ca32_o` unchanged.
- R7: When `ovf_en_i` is high and a second operand is present, `ov_o` is 1 exactly when both operands share a sign bit (bit 63) and the result's sign differs from it. `ov32_o` applies the same rule using bit 31.
- R8: When `ovf_en_i` and `div_ovf_vld_i` are both high, `ov_o` and `ov32_o` both take `div_ovf_i`, whatever the operands are.
- R9: `so_o` is set whenever an overflow update produces `ov_o` = 1. Only reset clears it.
- R10: When `ovf_en_i` is high but there is neither a second operand nor a divide overflow, `ov_o`, `ov32_o` and `so_o` keep their values.
- R11: When `rec_en_i` is high, `cr0_o` becomes {negative, positive, zero, summary overflow}. Bit 3 is negative, bit 0 is the summary-overflow value after this operation's update, and the sign is taken from the full 64-bit result. When `rec_en_i` is low, `cr0_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Load strobe for the flag registers |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| has_b_i | input | 1 | Second operand present |
| inv_a_i | input | 1 | Complement the first operand |
| imm_vld_i | input | 1 | Immediate replaces the second operand |
| imm_i | input | 64 | Immediate value |
| res_i | input | 64 | Operation result |
| add_op_i | input | 1 | Add-type operation (XOR rule for half carry) |
| carry_en_i | input | 1 | Update carry flags |
| ovf_en_i | input | 1 | Update overflow flags |
| rec_en_i | input | 1 | Update condition field |
| div_ovf_vld_i | input | 1 | Divide overflow supplied |
| div_ovf_i | input | 1 | Divide overflow value |
| carry_done_i | input | 2 | Bit 0 protects ca_o, bit 1 protects ca32_o |
| ca_o | output | 1 | Carry |
| ca32_o | output | 1 | Half-width carry |
| ov_o | output | 1 | Overflow |
| ov32_o | output | 1 | Half-width overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr0_o | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The assertions assume the control inputs are known, 0 or 1, on every clock edge where `rst_n` is high, and that `valid_i` marks a single, complete set of operands. The bench keeps to this by changing inputs only on falling edges. It holds `valid_i` high for exactly one rising edge per operation and lowers it before the next operation's inputs are applied. It drives every control input to a defined level at all times, including while idle.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int unsigned XLEN_DEF = 64;
  localparam int unsigned NOPS     = 2;

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
    logic so;
  } xflags_t;
endpackage

// File: rtl/flag_carry_unit.sv
module flag_carry_unit #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            b_vld,
  input  logic [XLEN-1:0] res,
  input  logic            add_op,
  output logic            ca,
  output logic            ca32
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned NOPS = flag_pkg::NOPS;

  logic [NOPS-1:0][XLEN-1:0] ops;
  logic [NOPS-1:0]           op_vld;
  logic [NOPS-1:0]           gt_full;
  logic [NOPS-1:0]           gt_low;

  assign ops    = {opb, opa};
  assign op_vld = {b_vld, 1'b1};

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_cmp
    assign gt_full[gi] = op_vld[gi] && (ops[gi] > res);
    assign gt_low[gi]  = op_vld[gi] && (ops[gi][HALF-1:0] > res[HALF-1:0]);
  end

  assign ca   = |gt_full;
  assign ca32 = add_op ? (res[HALF] ^ opa[HALF] ^ (b_vld & opb[HALF]))
                       : |gt_low;
endmodule

// File: rtl/flag_ovf_unit.sv
module flag_ovf_unit #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            b_vld,
  input  logic [XLEN-1:0] res,
  input  logic            div_vld,
  input  logic            div_ovf,
  output logic            upd,
  output logic            ov,
  output logic            ov32
);
  localparam int unsigned HALF = XLEN / 2;

  logic ov_arith;
  logic ov32_arith;

  assign ov_arith   = (opa[XLEN-1] == opb[XLEN-1]) && (res[XLEN-1] != opa[XLEN-1]);
  assign ov32_arith = (opa[HALF-1] == opb[HALF-1]) && (res[HALF-1] != opa[HALF-1]);

  assign upd  = div_vld | b_vld;
  assign ov   = div_vld ? div_ovf : ov_arith;
  assign ov32 = div_vld ? div_ovf : ov32_arith;
endmodule

// File: rtl/flag_cr_unit.sv
module flag_cr_unit #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] res,
  input  logic            so,
  output logic [3:0]      cr0
);
  logic neg;
  logic zero;

  assign neg  = res[XLEN-1];
  assign zero = (res == '0);
  assign cr0  = {neg, ~neg & ~zero, zero, so};
endmodule

// File: rtl/int_flag_gen.sv
module int_flag_gen #(
  parameter int unsigned XLEN = flag_pkg::XLEN_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic            has_b_i,
  input  logic            inv_a_i,
  input  logic            imm_vld_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] res_i,
  input  logic            add_op_i,
  input  logic            carry_en_i,
  input  logic            ovf_en_i,
  input  logic            rec_en_i,
  input  logic            div_ovf_vld_i,
  input  logic            div_ovf_i,
  input  logic [1:0]      carry_done_i,
  output logic            ca_o,
  output logic            ca32_o,
  output logic            ov_o,
  output logic            ov32_o,
  output logic            so_o,
  output logic [3:0]      cr0_o
);
  import flag_pkg::*;

  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] op_b;
  logic            b_vld;

  logic    ca_c, ca32_c;
  logic    ovf_upd, ov_c, ov32_c;
  logic [3:0] cr0_c;

  xflags_t flg_q, flg_d;
  logic [3:0] cr0_q, cr0_d;

  // operand forming
  assign op_a  = inv_a_i ? ~opa_i : opa_i;
  assign op_b  = imm_vld_i ? imm_i : opb_i;
  assign b_vld = has_b_i | imm_vld_i;

  flag_carry_unit #(.XLEN(XLEN)) carry_u (
    .opa(op_a), .opb(op_b), .b_vld(b_vld), .res(res_i),
    .add_op(add_op_i), .ca(ca_c), .ca32(ca32_c)
  );

  flag_ovf_unit #(.XLEN(XLEN)) ovf_u (
    .opa(op_a), .opb(op_b), .b_vld(b_vld), .res(res_i),
    .div_vld(div_ovf_vld_i), .div_ovf(div_ovf_i),
    .upd(ovf_upd), .ov(ov_c), .ov32(ov32_c)
  );

  flag_cr_unit #(.XLEN(XLEN)) cr_u (
    .res(res_i), .so(flg_d.so), .cr0(cr0_c)
  );

  // next state
  always_comb begin
    flg_d = flg_q;
    cr0_d = cr0_q;
    if (carry_en_i && !carry_done_i[0]) flg_d.ca   = ca_c;
    if (carry_en_i && !carry_done_i[1]) flg_d.ca32 = ca32_c;
    if (ovf_en_i && ovf_upd) begin
      flg_d.ov   = ov_c;
      flg_d.ov32 = ov32_c;
      flg_d.so   = flg_q.so | ov_c;
    end
    if (rec_en_i) cr0_d = cr0_c;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      cr0_q <= '0;
    end else if (valid_i) begin
      flg_q <= flg_d;
      cr0_q <= cr0_d;
    end
  end

  assign ca_o   = flg_q.ca;
  assign ca32_o = flg_q.ca32;
  assign ov_o   = flg_q.ov;
  assign ov32_o = flg_q.ov32;
  assign so_o   = flg_q.so;
  assign cr0_o  = cr0_q;
endmodule

// File: rtl/int_flag_gen_chk.sv
module int_flag_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic       ovf_en_i,
  input logic       rec_en_i,
  input logic       div_ovf_vld_i,
  input logic [1:0] carry_done_i,
  input logic       ca_o,
  input logic       ca32_o,
  input logic       ov_o,
  input logic       ov32_o,
  input logic       so_o,
  input logic [3:0] cr0_o
);
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable({ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o}));

  a_r6_ca_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && carry_done_i[0]) |=> $stable(ca_o));

  a_r6_ca32_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && carry_done_i[1]) |=> $stable(ca32_o));

  a_r8_div_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ovf_en_i && div_ovf_vld_i) |=> (ov_o == ov32_o));

  a_r9_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    so_o |=> so_o);

  a_r9_so_follows_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ovf_en_i) |=> (!ov_o || so_o));

  a_r11_cr0_class: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && rec_en_i) |=> ($countones(cr0_o[3:1]) == 1 && cr0_o[0] == so_o));
endmodule

bind int_flag_gen int_flag_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ovf_en_i(ovf_en_i),
  .rec_en_i(rec_en_i), .div_ovf_vld_i(div_ovf_vld_i),
  .carry_done_i(carry_done_i), .ca_o(ca_o), .ca32_o(ca32_o),
  .ov_o(ov_o), .ov32_o(ov32_o), .so_o(so_o), .cr0_o(cr0_o)
);

// File: tb/int_flag_gen_tb_top.sv
module int_flag_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, has_b_i, inv_a_i, imm_vld_i, add_op_i;
  logic        carry_en_i, ovf_en_i, rec_en_i, div_ovf_vld_i, div_ovf_i;
  logic [1:0]  carry_done_i;
  logic [63:0] opa_i, opb_i, imm_i, res_i;
  logic        ca_o, ca32_o, ov_o, ov32_o, so_o;
  logic [3:0]  cr0_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  int_flag_gen dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opa_i(opa_i), .opb_i(opb_i),
    .has_b_i(has_b_i), .inv_a_i(inv_a_i), .imm_vld_i(imm_vld_i), .imm_i(imm_i),
    .res_i(res_i), .add_op_i(add_op_i), .carry_en_i(carry_en_i),
    .ovf_en_i(ovf_en_i), .rec_en_i(rec_en_i), .div_ovf_vld_i(div_ovf_vld_i),
    .div_ovf_i(div_ovf_i), .carry_done_i(carry_done_i), .ca_o(ca_o),
    .ca32_o(ca32_o), .ov_o(ov_o), .ov32_o(ov32_o), .so_o(so_o), .cr0_o(cr0_o)
  );

  typedef struct packed {
    logic        add;
    logic        inv;
    logic        immv;
    logic [1:0]  done;
    logic        cen;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] imm;
    logic [63:0] res;
    logic        e_ca;
    logic        e_ca32;
    logic [3:0]  e_cr0;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // add, small positive
    '{1'b1,1'b0,1'b0,2'b00,1'b1, 64'd1, 64'd2, 64'd0, 64'd3, 1'b0,1'b0,4'b0100},
    // add wrapping to zero: full carry, XOR half carry
    '{1'b1,1'b0,1'b0,2'b00,1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 64'd0, 1'b1,1'b1,4'b0010},
    // add crossing bit 32
    '{1'b1,1'b0,1'b0,2'b00,1'b1, 64'h0000_0000_FFFF_FFFF, 64'd1, 64'd0, 64'h0000_0001_0000_0000, 1'b0,1'b1,4'b0100},
    // non-add, operand above result in both widths
    '{1'b0,1'b0,1'b0,2'b00,1'b1, 64'h10, 64'h5, 64'd0, 64'h8, 1'b1,1'b1,4'b0100},
    // non-add, only low half compares greater
    '{1'b0,1'b0,1'b0,2'b00,1'b1, 64'd1, 64'd2, 64'd0, 64'h7FFF_FFFF_0000_0000, 1'b0,1'b1,4'b0100},
    // inverted first operand
    '{1'b1,1'b1,1'b0,2'b00,1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 64'd0, 64'h10, 1'b0,1'b0,4'b0100},
    // immediate replaces large second operand
    '{1'b1,1'b0,1'b1,2'b00,1'b1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd5, 1'b0,1'b0,4'b0100},
    // negative result
    '{1'b1,1'b0,1'b0,2'b00,1'b1, 64'hFFFF_FFFF_FFFF_FFFD, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0,1'b0,4'b1000},
    // both carries protected: stay 0
    '{1'b0,1'b0,1'b0,2'b11,1'b1, 64'h10, 64'h5, 64'd0, 64'h8, 1'b0,1'b0,4'b0100},
    // only full carry protected
    '{1'b0,1'b0,1'b0,2'b01,1'b1, 64'h10, 64'h5, 64'd0, 64'h8, 1'b0,1'b1,4'b0100},
    // carry disabled: keep previous 0/1
    '{1'b1,1'b0,1'b0,2'b00,1'b0, 64'd1, 64'd2, 64'd0, 64'd3, 1'b0,1'b1,4'b0100}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    valid_i = 0; has_b_i = 1; inv_a_i = 0; imm_vld_i = 0; add_op_i = 1;
    carry_en_i = 1; ovf_en_i = 1; rec_en_i = 1; div_ovf_vld_i = 0;
    div_ovf_i = 0; carry_done_i = 0; opa_i = 0; opb_i = 0; imm_i = 0; res_i = 0;
  endtask

  task automatic fire();
    valid_i = 1;
    @(negedge clk);
    valid_i = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", {ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o}, 0);

    // table: R2 R3 R4 R5 R6 R11, no overflow expected anywhere
    for (int i = 0; i < NV; i++) begin
      idle();
      add_op_i = VECS[i].add; inv_a_i = VECS[i].inv; imm_vld_i = VECS[i].immv;
      carry_done_i = VECS[i].done; carry_en_i = VECS[i].cen;
      opa_i = VECS[i].a; opb_i = VECS[i].b; imm_i = VECS[i].imm; res_i = VECS[i].res;
      fire();
      chk($sformatf("R3 ca vec%0d", i), ca_o, VECS[i].e_ca);
      chk($sformatf("R4 R5 R6 ca32 vec%0d", i), ca32_o, VECS[i].e_ca32);
      chk($sformatf("R7 no ovf vec%0d", i), {ov_o, ov32_o, so_o}, 0);
      chk($sformatf("R11 cr0 vec%0d", i), cr0_o, VECS[i].e_cr0);
    end

    // R7 R9: full-width overflow
    idle();
    opa_i = 64'h7FFF_FFFF_FFFF_FFFF; opb_i = 1; res_i = 64'h8000_0000_0000_0000;
    fire();
    chk("R7 ov full", {ov_o, ov32_o}, 2'b10);
    chk("R9 so set", so_o, 1);
    chk("R11 cr0 neg with so", cr0_o, 4'b1001);

    // R7 half-width overflow, R9 so stays
    idle();
    opa_i = 64'h7FFF_FFFF; opb_i = 1; res_i = 64'h8000_0000;
    fire();
    chk("R7 ov32", {ov_o, ov32_o}, 2'b01);
    chk("R9 so sticky", so_o, 1);
    chk("R11 cr0 pos with so", cr0_o, 4'b0101);

    // R10: no second operand, no divide overflow
    idle();
    has_b_i = 0; opa_i = 64'h7FFF_FFFF; res_i = 0;
    fire();
    chk("R10 ov unchanged", {ov_o, ov32_o, so_o}, 3'b011);
    chk("R11 cr0 zero", cr0_o, 4'b0011);

    // R8: divide overflow set
    idle();
    has_b_i = 0; div_ovf_vld_i = 1; div_ovf_i = 1; res_i = 5;
    fire();
    chk("R8 div sets", {ov_o, ov32_o}, 2'b11);

    // R8 R9: divide overflow clear overrides arithmetic overflow; so stays
    idle();
    div_ovf_vld_i = 1; div_ovf_i = 0;
    opa_i = 64'h7FFF_FFFF_FFFF_FFFF; opb_i = 1; res_i = 64'h8000_0000_0000_0000;
    fire();
    chk("R8 div clears", {ov_o, ov32_o}, 2'b00);
    chk("R9 so not cleared", so_o, 1);

    // R11: record disabled keeps cr0
    idle();
    rec_en_i = 0; res_i = 0; opa_i = 0; opb_i = 0;
    fire();
    chk("R11 cr0 kept", cr0_o, 4'b1001);

    // R1: no strobe, nothing changes
    idle();
    opa_i = 64'hFFFF_FFFF_FFFF_FFFF; opb_i = 64'h7FFF_FFFF_FFFF_FFFF; res_i = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle hold", {ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o}, {5'b00001, 4'b1001});

    // R1: reset clears sticky state
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset again", {ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule